// File: doc/BRIEF.md
# Grouped Level-Interrupt Combiner

The combiner takes a wide vector of level-sensitive interrupt lines, splits it into groups of eight adjacent lines, and drives one output per group. A group output is high whenever at least one of its lines is both pending and enabled. Downstream, each group output feeds one input of a separate interrupt controller, which handles priority and vectoring.

Pending state is a registered copy of the input levels. It sets and clears with the inputs, so nothing is latched. Software manages the per-line enables through a word-addressed register window. Each 16-byte quad in that window serves four consecutive groups, and each group takes one byte lane. Enables are changed only through separate write-one-to-set and write-one-to-clear words. Two read-only summary words at the end of the window mirror the group outputs.

A build parameter selects an external-mode variant. In that variant, lines whose group index is at or above a configured limit are ignored.

Top module: `irq_combiner`

## Requirements
- R1: Input line n belongs to group n>>3 at bit n&7. Output `grp_irq_o[g]` is high exactly when some bit of group g is both pending and enabled.
- R2: Pending bits copy the input levels at each clock edge. A high line sets its bit and a low line clears it. The group output reflects the new level from that same edge.
- R3: A write to quad register 0 (offset bits [3:2] = 0) ORs byte lane k of the data into the enable mask of group 4q+k, where q is offset>>4. Zero bits leave the mask unchanged. The outputs reflect the new mask from the write edge.
- R4: A write to quad register 1 clears each enable bit whose data bit is 1. Zero bits leave the mask unchanged.
- R5: Quad register 2 reads the raw pending bits, with group 4q+k in byte lane k (bits 8k+7..8k).
- R6: Quad register 3 reads pending AND enable in the same lane layout.
- R7: Offset 0x100 reads the outputs of groups 0..31 at bit n = group n. Offset 0x104 reads the outputs of groups 32..63 at bit n = group 32+n.
- R8: After reset all enables and pending bits are zero. Reads of quad registers 0 and 1 return the last value written there. After reset they read zero, except offsets 0xC0, 0xC4, 0xD0 and 0xD4, which read 0x01010101.
- R9: Writes to quad registers 2 or 3, to the summary words, or at offsets 0x108 and above change no enable and no stored word. Each such write raises `err_o` for exactly one cycle. Legal writes leave `err_o` low.
- R10: Read data is registered and appears the cycle after the read request. Reads at offsets 0x108 and above return zero.
- R11: With external mode enabled, groups at or above the configured limit keep zero pending state and a low output, whatever their inputs and enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_GROUPS*8 | Level-sensitive interrupt lines |
| req_valid_i | input | 1 | Single-cycle register access strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (9) | Byte offset into the register window |
| req_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle pulse after an illegal write |
| grp_irq_o | output | NUM_GROUPS | Per-group combined interrupt |

## Verification
Inputs are driven on the falling edge, and every result is due at the next rising edge. The bench therefore samples at the falling edge that follows: one edge of latency for pending capture, enable updates, read data and the error pulse alike. The group outputs are combinational from the registered state, so they share the latency of that state. The error pulse is checked again one cycle later to confirm it has dropped. Read checks compare against the model state from before the read edge, and no input changes in the same cycle as a read.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;
  localparam int unsigned SRC_PER_GRP  = 8;
  localparam int unsigned GRP_PER_QUAD = 4;
  localparam int unsigned QUAD_BYTES   = 16;
  localparam logic [31:0] EN_PRESET    = 32'h0101_0101;

  typedef enum logic [1:0] {
    REG_EN_SET = 2'd0,
    REG_EN_CLR = 2'd1,
    REG_RAW    = 2'd2,
    REG_MSK    = 2'd3
  } quad_reg_e;

  function automatic int unsigned region_bytes(input int unsigned ngrp);
    return (ngrp / GRP_PER_QUAD) * QUAD_BYTES + ((ngrp + 31) / 32) * 4;
  endfunction

  function automatic int unsigned addr_w(input int unsigned ngrp);
    return $clog2(region_bytes(ngrp));
  endfunction

  // reset value of a stored enable word, by byte offset
  function automatic logic [31:0] en_reset_val(input int unsigned off);
    return (off == 'hC0 || off == 'hC4 || off == 'hD0 || off == 'hD4) ? EN_PRESET : 32'h0;
  endfunction
endpackage

// File: rtl/irq_comb_group.sv
module irq_comb_group
  import irq_comb_pkg::*;
#(
  parameter bit BLOCKED = 1'b0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [SRC_PER_GRP-1:0] src_i,
  input  logic [SRC_PER_GRP-1:0] set_i,
  input  logic [SRC_PER_GRP-1:0] clr_i,
  output logic [SRC_PER_GRP-1:0] pend_o,
  output logic [SRC_PER_GRP-1:0] mask_o,
  output logic                   irq_o
);
  logic [SRC_PER_GRP-1:0] pend_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= (mask_q | set_i) & ~clr_i;
  end

  generate
    if (BLOCKED) begin : g_blocked
      logic unused_src;
      assign unused_src = ^src_i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q <= '0;
        else         pend_q <= '0;
      end
      // R11
      blocked_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend_q == '0);
    end else begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q <= '0;
        else         pend_q <= src_i;
      end
      // R2
      pend_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> pend_q == $past(src_i));
    end
  endgenerate

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign irq_o  = |(pend_q & mask_q);

  // R3
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> (mask_q & $past(set_i)) == $past(set_i));
  // R4
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> (mask_q & $past(clr_i)) == '0);
  // R9
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(mask_q));
endmodule

// File: rtl/irq_comb_regs.sv
module irq_comb_regs
  import irq_comb_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 64,
  parameter int unsigned ADDR_W     = 9
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              req_valid_i,
  input  logic                              req_write_i,
  input  logic [ADDR_W-1:0]                 req_addr_i,
  input  logic [31:0]                       req_wdata_i,
  input  logic [NUM_GROUPS*SRC_PER_GRP-1:0] raw_i,
  input  logic [NUM_GROUPS*SRC_PER_GRP-1:0] msk_i,
  input  logic [NUM_GROUPS-1:0]             grp_irq_i,
  output logic [NUM_GROUPS*SRC_PER_GRP-1:0] set_o,
  output logic [NUM_GROUPS*SRC_PER_GRP-1:0] clr_o,
  output logic [31:0]                       rd_data_o,
  output logic                              err_o
);
  localparam int unsigned NQUAD     = NUM_GROUPS / GRP_PER_QUAD;
  localparam int unsigned NSHADOW   = NQUAD * 2;
  localparam int unsigned SUM_WORDS = (NUM_GROUPS + 31) / 32;
  localparam int unsigned SUM_BASE  = NQUAD * QUAD_BYTES;
  localparam int unsigned REGION    = region_bytes(NUM_GROUPS);
  localparam int unsigned QW        = (NQUAD > 1) ? $clog2(NQUAD) : 1;
  localparam int unsigned SW        = (SUM_WORDS > 1) ? $clog2(SUM_WORDS) : 1;

  logic [ADDR_W-5:0]       quad_idx;
  logic [QW-1:0]           qsel;
  quad_reg_e               reg_sel;
  logic                    in_grp, in_sum, wr_ok, wr_bad, rd_req;
  logic [ADDR_W-1:0]       sum_off;
  logic [SW-1:0]           sum_idx;
  logic [SUM_WORDS*32-1:0] sum_pad;
  logic [31:0]             rd_next, rd_q;
  logic                    err_q;
  logic [31:0]             shadow_q [NSHADOW];

  assign quad_idx = req_addr_i[ADDR_W-1:4];
  assign qsel     = quad_idx[QW-1:0];
  assign reg_sel  = quad_reg_e'(req_addr_i[3:2]);
  assign in_grp   = quad_idx < (ADDR_W-4)'(NQUAD);
  assign in_sum   = (req_addr_i >= ADDR_W'(SUM_BASE)) && (req_addr_i < ADDR_W'(REGION));
  assign sum_off  = req_addr_i - ADDR_W'(SUM_BASE);
  assign sum_idx  = sum_off[2 +: SW];
  assign sum_pad  = (SUM_WORDS*32)'(grp_irq_i);
  assign rd_req   = req_valid_i && !req_write_i;
  assign wr_ok    = req_valid_i && req_write_i && in_grp && !reg_sel[1];
  assign wr_bad   = req_valid_i && req_write_i && !wr_ok;

  logic unused_addr;
  assign unused_addr = ^{req_addr_i[1:0], sum_off, quad_idx};

  generate
    for (genvar q = 0; q < NQUAD; q++) begin : g_quad
      logic hit;
      assign hit = wr_ok && (qsel == QW'(q));
      assign set_o[q*32 +: 32] = (hit && reg_sel == REG_EN_SET) ? req_wdata_i : '0;
      assign clr_o[q*32 +: 32] = (hit && reg_sel == REG_EN_CLR) ? req_wdata_i : '0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSHADOW; i++)
        shadow_q[i] <= en_reset_val((i / 2) * QUAD_BYTES + (i % 2) * 4);
    end else if (wr_ok) begin
      shadow_q[{qsel, reg_sel[0]}] <= req_wdata_i;
    end
  end

  always_comb begin
    rd_next = '0;
    if (in_grp) begin
      unique case (reg_sel)
        REG_EN_SET, REG_EN_CLR: rd_next = shadow_q[{qsel, reg_sel[0]}];
        REG_RAW:                rd_next = raw_i[qsel*32 +: 32];
        REG_MSK:                rd_next = msk_i[qsel*32 +: 32];
        default:                rd_next = '0;
      endcase
    end else if (in_sum) begin
      rd_next = sum_pad[sum_idx*32 +: 32];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= wr_bad;
      if (rd_req) rd_q <= rd_next;
    end
  end

  assign rd_data_o = rd_q;
  assign err_o     = err_q;

  // R9
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_valid_i && req_write_i));
  // R3
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({|set_o, |clr_o}));
  // R10
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && req_addr_i >= ADDR_W'(REGION)) |=> rd_data_o == '0);
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irq_comb_pkg::*;
#(
  parameter int unsigned NUM_GROUPS     = 64,
  parameter bit          EXT_MODE       = 1'b0,
  parameter int unsigned EXT_MAX_GROUPS = 64
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic [NUM_GROUPS*SRC_PER_GRP-1:0]         irq_i,
  input  logic                                      req_valid_i,
  input  logic                                      req_write_i,
  input  logic [addr_w(NUM_GROUPS)-1:0]             req_addr_i,
  input  logic [31:0]                               req_wdata_i,
  output logic [31:0]                               rd_data_o,
  output logic                                      err_o,
  output logic [NUM_GROUPS-1:0]                     grp_irq_o
);
  localparam int unsigned ADDR_W = addr_w(NUM_GROUPS);
  localparam int unsigned NB     = NUM_GROUPS * SRC_PER_GRP;

  logic [NB-1:0] pend_w, mask_w, set_w, clr_w, msk_w;

  generate
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      irq_comb_group #(
        .BLOCKED (EXT_MODE && (g >= EXT_MAX_GROUPS))
      ) u_grp (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  (irq_i[g*SRC_PER_GRP +: SRC_PER_GRP]),
        .set_i  (set_w[g*SRC_PER_GRP +: SRC_PER_GRP]),
        .clr_i  (clr_w[g*SRC_PER_GRP +: SRC_PER_GRP]),
        .pend_o (pend_w[g*SRC_PER_GRP +: SRC_PER_GRP]),
        .mask_o (mask_w[g*SRC_PER_GRP +: SRC_PER_GRP]),
        .irq_o  (grp_irq_o[g])
      );
    end
  endgenerate

  assign msk_w = pend_w & mask_w;

  irq_comb_regs #(
    .NUM_GROUPS (NUM_GROUPS),
    .ADDR_W     (ADDR_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .raw_i       (pend_w),
    .msk_i       (msk_w),
    .grp_irq_i   (grp_irq_o),
    .set_o       (set_w),
    .clr_o       (clr_w),
    .rd_data_o   (rd_data_o),
    .err_o       (err_o)
  );
endmodule

// File: tb/irq_combiner_tb_top.sv
`timescale 1ns/1ps
module irq_combiner_tb_top;
  localparam int NG = 64;
  localparam int NB = NG * 8;
  localparam int EXT_LIM = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] irq = '0;
  logic          vld = 1'b0, wr = 1'b0;
  logic [8:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata, rdata_x;
  logic          err, err_x;
  logic [NG-1:0] gout, gout_x;

  int total = 0, bad = 0;

  logic [7:0]  m_mask [NG];
  logic [31:0] m_shadow [32];

  always #4 clk = ~clk;

  irq_combiner #(.NUM_GROUPS(NG)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .req_valid_i(vld), .req_write_i(wr),
    .req_addr_i(addr), .req_wdata_i(wdata), .rd_data_o(rdata), .err_o(err), .grp_irq_o(gout));

  irq_combiner #(.NUM_GROUPS(NG), .EXT_MODE(1'b1), .EXT_MAX_GROUPS(EXT_LIM)) dut_ext_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .req_valid_i(vld), .req_write_i(wr),
    .req_addr_i(addr), .req_wdata_i(wdata), .rd_data_o(rdata_x), .err_o(err_x), .grp_irq_o(gout_x));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [NG-1:0] exp_out(input bit ext);
    logic [NG-1:0] o;
    for (int g = 0; g < NG; g++)
      o[g] = (|(irq[g*8 +: 8] & m_mask[g])) && !(ext && g >= EXT_LIM);
    return o;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [8:0] a);
    logic [31:0] v;
    logic [NG-1:0] o;
    int q;
    v = '0;
    o = exp_out(1'b0);
    q = int'(a >> 4);
    if (a < 9'h100) begin
      case (a[3:2])
        2'd0, 2'd1: v = m_shadow[q*2 + int'(a[2])];
        2'd2: v = irq[q*32 +: 32];
        default: for (int k = 0; k < 4; k++) v[k*8 +: 8] = irq[(q*4+k)*8 +: 8] & m_mask[q*4+k];
      endcase
    end else if (a < 9'h104) v = o[31:0];
    else if (a < 9'h108) v = o[63:32];
    return v;
  endfunction

  task automatic check_outs(input string req);
    chk({req, " grp_irq"}, gout, exp_out(1'b0));
    chk("R11 ext grp_irq", gout_x, exp_out(1'b1));
  endtask

  task automatic drive_irq(input logic [NB-1:0] v, input string req);
    irq = v;
    @(negedge clk);
    check_outs(req);
  endtask

  task automatic reg_wr(input logic [8:0] a, input logic [31:0] d, input string req);
    bit legal;
    int q;
    legal = (a < 9'h100) && !a[3];
    vld = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    vld = 1'b0; wr = 1'b0;
    if (legal) begin
      q = int'(a >> 4);
      m_shadow[q*2 + int'(a[2])] = d;
      for (int k = 0; k < 4; k++)
        if (!a[2]) m_mask[q*4+k] = m_mask[q*4+k] | d[k*8 +: 8];
        else       m_mask[q*4+k] = m_mask[q*4+k] & ~d[k*8 +: 8];
    end
    chk({req, " err"}, 64'(err), 64'(!legal));
    check_outs(req);
    @(negedge clk);
    chk("R9 err one cycle", 64'(err), 64'h0);
  endtask

  task automatic reg_rd(input logic [8:0] a, input string req);
    logic [31:0] e;
    e = exp_rd(a);
    vld = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    vld = 1'b0;
    chk(req, 64'(rdata), 64'(e));
  endtask

  function automatic logic [NB-1:0] rnd_vec();
    logic [NB-1:0] v;
    for (int i = 0; i < NB/32; i++) v[i*32 +: 32] = $urandom & $urandom;
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0b_5eed));
    for (int g = 0; g < NG; g++) m_mask[g] = '0;
    for (int i = 0; i < 32; i++)
      m_shadow[i] = (i == 24 || i == 25 || i == 26 || i == 27) ? 32'h0101_0101 : 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 reset grp_irq", gout, '0);
    reg_rd(9'h0C0, "R8 preset 0xC0");
    reg_rd(9'h0D4, "R8 preset 0xD4");
    reg_rd(9'h000, "R8 reset word 0x00");
    reg_rd(9'h00C, "R8 reset masked status");

    // R1 line 13 -> group 1 bit 5
    drive_irq(NB'(1) << 13, "R2 pend only");
    chk("R1 no enable no out", gout, '0);
    reg_rd(9'h008, "R5 raw line 13");
    reg_wr(9'h000, 32'h0000_2000, "R3 set grp1 bit5");
    chk("R1 group 1 asserted", gout, 64'h2);
    reg_wr(9'h000, 32'h0, "R3 zero set no effect");
    reg_rd(9'h00C, "R6 masked line 13");
    reg_rd(9'h100, "R7 summary low");
    drive_irq('0, "R2 level low clears");
    chk("R2 out drops", gout, '0);
    drive_irq(NB'(1) << 13, "R2 level high again");
    reg_wr(9'h004, 32'h0, "R4 zero clear no effect");
    reg_wr(9'h004, 32'h0000_2000, "R4 clear grp1 bit5");
    chk("R4 out dropped", gout, '0);
    reg_rd(9'h000, "R8 readback set word");

    // high groups and summary word 1, external limit
    reg_wr(9'h0F0, 32'hFFFF_FFFF, "R3 set quad15");
    reg_wr(9'h0A0, 32'hFF00_00FF, "R3 set quad10");
    drive_irq({NB{1'b1}}, "R11 all lines high");
    reg_rd(9'h104, "R7 summary high");
    reg_rd(9'h0F8, "R5 raw quad15");

    // R9 illegal writes
    reg_wr(9'h0F8, 32'h0, "R9 write raw status");
    reg_wr(9'h0FC, 32'h0, "R9 write masked status");
    reg_wr(9'h100, 32'hFFFF_FFFF, "R9 write summary");
    reg_wr(9'h104, 32'hFFFF_FFFF, "R9 write summary hi");
    reg_wr(9'h108, 32'hFFFF_FFFF, "R9 write past region");
    reg_wr(9'h1F0, 32'hFFFF_FFFF, "R9 write far");
    reg_rd(9'h0F0, "R9 stored word unchanged");
    reg_rd(9'h0FC, "R9 masks unchanged");

    // R10 unmapped reads
    reg_rd(9'h108, "R10 unmapped 0x108");
    reg_rd(9'h1FC, "R10 unmapped 0x1FC");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      logic [8:0] a;
      op = int'($urandom % 10);
      if (op < 3) drive_irq(rnd_vec(), "R2 random lines");
      else if (op < 7) begin
        if (($urandom % 5) != 0) a = {($urandom % 16) == 0 ? 5'd0 : 5'($urandom % 16), 2'($urandom % 2), 2'b00};
        else a = {7'($urandom), 2'b00};
        reg_wr(a, $urandom & $urandom, "R3 R4 random write");
      end else begin
        a = {7'($urandom), 2'b00};
        reg_rd(a, "R5 R6 R7 random read");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule